// File: doc/BRIEF.md
# Shared-Pin Parallel Port Controller

This block drives and samples a group of device pins that are shared with on-chip peripherals. For each pin it keeps a direction bit and an output latch bit. It also passes the pin level through a two-stage synchronizer. Software reaches these through a small register bus with three meaningful addresses: direction, latch and port.

Writes to the port address land in the output latch. Reads of the port address return the synchronized pin levels, while reads of the latch address return the stored latch value. Writes are qualified by byte-wide enables.

Each pin has a pair of output multiplexers. They hand the pad's output data and output enable to the peripheral whenever that peripheral is enabled and asserting its own output enable. The synchronized pin level is always forwarded to the peripheral input path. A parameter mask marks which pins exist: absent pins read as zero, ignore writes and are never driven.

Top module: `shared_pin_port`

## Requirements
- R1: For a pin controlled by the port, a direction bit of 0 makes the pin an output and 1 makes it an input: pad_oe equals the inverted direction bit, and pad_out equals the latch bit.
- R2: After a synchronous active-low reset, every implemented direction bit is 1 and the latch is 0, so no pad is driven.
- R3: A read at address 1 (latch) returns the output latch contents, not the pin levels.
- R4: A read at address 2 (port) returns the pin levels delayed by two clocks through the synchronizer. A write at address 2 updates the output latch.
- R5: When per_en and per_oe are both 1 for a pin, pad_oe is 1 and pad_out follows per_dout. The port's direction bit and latch have no effect on that pad.
- R6: A pin owned by the peripheral can still be read through the port address.
- R7: When per_en is 1 but per_oe is 0, the direction bit and latch control the pin as in R1.
- R8: Bits cleared in IMPL_MASK read as zero at the direction, latch and port addresses. Writes to them are ignored, and their pad_oe, pad_out and per_din stay 0.
- R9: per_din carries the synchronized pin level (two clocks of delay) for every implemented pin, whoever owns the output.
- R10: A write takes effect at the clock edge where bus_wr and the address are valid. Only bytes whose bus_be bit (bit k covers data bits 8k..8k+7) is 1 are changed.
- R11: Address 0 selects direction. Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 none |
| bus_wdata | input | 8*NBYTES | Write data |
| bus_be | input | NBYTES | Byte write enables |
| bus_rdata | output | 8*NBYTES | Combinational read data |
| per_en | input | 8*NBYTES | Peripheral enable per pin |
| per_oe | input | 8*NBYTES | Peripheral output enable per pin |
| per_dout | input | 8*NBYTES | Peripheral output data per pin |
| per_din | output | 8*NBYTES | Synchronized pin level to peripheral |
| pad_in | input | 8*NBYTES | Raw pin level from pad |
| pad_out | output | 8*NBYTES | Output data to pad |
| pad_oe | output | 8*NBYTES | Output enable to pad |

## Verification
The embedded assertions check on every cycle that:
- peripheral-owned pads follow the peripheral;
- port-owned pads follow the inverted direction bit;
- absent pins stay silent and read as zero;
- the synchronizer output equals the pin level of two clocks earlier;
- direction is all ones after reset;
- a full-width port-address write lands in the latch.

The directed scenarios are needed for the rest, because each depends on the order of stimulus rather than on a single cycle:
- the difference between latch and port reads;
- partial byte-enable writes;
- the inert address 3;
- the one-clock point at which a port read still shows the old level;
- ownership returning to the port when the peripheral drops its enable.

// File: rtl/spp_pkg.sv
// Package: shared definitions for the shared-pin parallel port.
// Assumes a two-bit register address on the bus.
package spp_pkg;
    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_PORT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/spp_sync.sv
// Two-flop synchronizer for the pad inputs.
// Assumes pad levels are asynchronous to clk; adds two clocks of latency.
module spp_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: shift the pad level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;

    AST_SYNC_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q_sync == $past(d_async, 2))); // R9
endmodule

// File: rtl/spp_regs.sv
// Direction and output-latch registers with byte write enables.
// Assumes the write selects are already decoded; bits absent from IMPL_MASK
// are held at zero.
module spp_regs #(
    parameter int              NBYTES    = 2,
    parameter int              NPINS     = 8 * NBYTES,
    parameter logic [NPINS-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_lat,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NBYTES-1:0] be,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  lat_q
);
    logic [NPINS-1:0] bit_we;

    // Purpose: expand byte enables to a per-bit write mask limited to real pins.
    for (genvar i = 0; i < NPINS; i++) begin : g_bitwe
        assign bit_we[i] = be[i / 8] & IMPL_MASK[i];
    end

    // Purpose: hold the direction bits; every real pin starts as an input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= IMPL_MASK;
        else if (wr_dir)
            dir_q <= (dir_q & ~bit_we) | (wdata & bit_we);
    end

    // Purpose: hold the output latch bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (wr_lat)
            lat_q <= (lat_q & ~bit_we) | (wdata & bit_we);
    end

    AST_RESET_DIR_INPUT: assert property (@(posedge clk)
        !rst_n |=> (dir_q == IMPL_MASK && lat_q == '0)); // R2
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dir && $past(rst_n)) |=> $stable(dir_q)); // R10
    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q | lat_q) & ~IMPL_MASK) == '0); // R8
endmodule

// File: rtl/spp_pin_mux.sv
// Per-pin output ownership multiplexers.
// Assumes the peripheral owns a pin only while both its enable and its output
// enable are high; absent pins are never driven.
module spp_pin_mux #(
    parameter int               NPINS     = 16,
    parameter logic [NPINS-1:0] IMPL_MASK = '1
) (
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] lat_q,
    input  logic [NPINS-1:0] per_en,
    input  logic [NPINS-1:0] per_oe,
    input  logic [NPINS-1:0] per_dout,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_real
            logic periph_owns;
            // Purpose: pick the owner of this pin's data and enable.
            always_comb begin
                periph_owns = per_en[i] & per_oe[i];
                pad_oe[i]   = periph_owns ? per_oe[i]   : ~dir_q[i];
                pad_out[i]  = periph_owns ? per_dout[i] : lat_q[i];
            end
        end else begin : g_absent
            assign pad_oe[i]  = 1'b0;
            assign pad_out[i] = 1'b0;
        end
    end
endmodule

// File: rtl/shared_pin_port.sv
// Top: shared-pin parallel port with peripheral override.
// Assumes a single clock domain for the bus; pad inputs are asynchronous.
// Address 0 direction, 1 latch, 2 port, 3 unused.
module shared_pin_port
    import spp_pkg::*;
#(
    parameter int                    NBYTES    = 2,
    parameter logic [8*NBYTES-1:0]   IMPL_MASK = 16'h7EFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_addr,
    input  logic [8*NBYTES-1:0]   bus_wdata,
    input  logic [NBYTES-1:0]     bus_be,
    output logic [8*NBYTES-1:0]   bus_rdata,
    input  logic [8*NBYTES-1:0]   per_en,
    input  logic [8*NBYTES-1:0]   per_oe,
    input  logic [8*NBYTES-1:0]   per_dout,
    output logic [8*NBYTES-1:0]   per_din,
    input  logic [8*NBYTES-1:0]   pad_in,
    output logic [8*NBYTES-1:0]   pad_out,
    output logic [8*NBYTES-1:0]   pad_oe
);
    localparam int NPINS = 8 * NBYTES;

    reg_sel_e         sel;
    logic             wr_dir;
    logic             wr_lat;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] lat_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] pin_level;
    logic [NPINS-1:0] owned;

    // Purpose: decode the write target; a port-address write goes to the latch.
    always_comb begin
        sel    = reg_sel_e'(bus_addr);
        wr_dir = bus_wr && (sel == SEL_DIR);
        wr_lat = bus_wr && (sel == SEL_LAT || sel == SEL_PORT);
    end

    spp_regs #(
        .NBYTES    (NBYTES),
        .NPINS     (NPINS),
        .IMPL_MASK (IMPL_MASK)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_dir (wr_dir),
        .wr_lat (wr_lat),
        .wdata  (bus_wdata),
        .be     (bus_be),
        .dir_q  (dir_q),
        .lat_q  (lat_q)
    );

    spp_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pin_sync)
    );

    spp_pin_mux #(
        .NPINS     (NPINS),
        .IMPL_MASK (IMPL_MASK)
    ) u_mux (
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .per_en   (per_en),
        .per_oe   (per_oe),
        .per_dout (per_dout),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // Purpose: hide absent pins from both the port read and the peripheral.
    assign pin_level = pin_sync & IMPL_MASK;
    assign per_din   = pin_level;

    // Purpose: select the read source for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_DIR:  bus_rdata = dir_q;
            SEL_LAT:  bus_rdata = lat_q;
            SEL_PORT: bus_rdata = pin_level;
            default:  bus_rdata = '0;
        endcase
    end

    assign owned = per_en & per_oe & IMPL_MASK;

    AST_PERIPH_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & owned) == owned) && ((pad_out & owned) == (per_dout & owned))); // R5
    AST_PORT_DRIVES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~owned & IMPL_MASK) == (~dir_q & ~owned & IMPL_MASK))); // R1
    AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | per_din | bus_rdata) & ~IMPL_MASK) == '0); // R8
    AST_PORT_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && bus_be == '1) |=>
        (lat_q == ($past(bus_wdata) & IMPL_MASK))); // R4
endmodule

// File: tb/tb_shared_pin_port.sv
// Directed bench for shared_pin_port; one task per scenario.
module tb_shared_pin_port;
    localparam int          NB   = 2;
    localparam logic [15:0] MASK = 16'h7EFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic [15:0] per_en = '0, per_oe = '0, per_dout = '0, per_din;
    logic [15:0] pad_in = '0, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_dir, m_lat;

    shared_pin_port #(.NBYTES(NB), .IMPL_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .per_en(per_en), .per_oe(per_oe), .per_dout(per_dout), .per_din(per_din),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a != 2'd3) begin
            for (int i = 0; i < 16; i++) begin
                if (be[i/8] && MASK[i]) begin
                    if (a == 2'd0) m_dir[i] = d[i];
                    else m_lat[i] = d[i];
                end
            end
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] exp_oe();
        logic [15:0] own = per_en & per_oe;
        return ((own & per_oe) | (~own & ~m_dir)) & MASK;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] own = per_en & per_oe;
        return ((own & per_dout) | (~own & m_lat)) & MASK;
    endfunction

    task automatic t_reset();
        logic [15:0] r;
        bus_read(2'd0, r); check("R2 dir after reset", r, MASK);
        bus_read(2'd1, r); check("R2 latch after reset", r, 16'h0000);
        check("R2 pad_oe after reset", pad_oe, 16'h0000);
    endtask

    task automatic t_direction();
        logic [15:0] r;
        bus_write(2'd1, 16'h00A5, 2'b11);
        bus_write(2'd0, 16'hFF0F, 2'b11);
        bus_read(2'd0, r); check("R11 dir at address 0", r, 16'hFF0F & MASK);
        check("R1 pad_oe from direction", pad_oe, exp_oe());
        check("R1 pad_out from latch", pad_out, exp_out());
    endtask

    task automatic t_latch_vs_port();
        logic [15:0] r;
        @(negedge clk);
        pad_in = 16'h3C3C;
        @(negedge clk);
        bus_read(2'd2, r); check("R4 port read one clock later still old", r, 16'h0000);
        @(negedge clk);
        bus_read(2'd2, r); check("R4 port read after two clocks", r, 16'h3C3C & MASK);
        bus_read(2'd1, r); check("R3 latch read ignores pins", r, 16'h00A5);
        check("R9 per_din follows pins", per_din, 16'h3C3C & MASK);
        bus_write(2'd2, 16'h1155, 2'b11);
        bus_read(2'd1, r); check("R4 port write lands in latch", r, 16'h1155 & MASK);
        bus_read(2'd2, r); check("R4 port read still pins after write", r, 16'h3C3C & MASK);
    endtask

    task automatic t_periph();
        logic [15:0] r;
        bus_write(2'd0, 16'h0000, 2'b11);
        bus_write(2'd1, 16'h00F0, 2'b11);
        @(negedge clk);
        per_en = 16'h000F; per_oe = 16'h0003; per_dout = 16'h0002;
        #1;
        check("R5 owned pads enabled by peripheral", pad_oe & 16'h0003, 16'h0003);
        check("R5 owned pads carry peripheral data", pad_out & 16'h0003, 16'h0002);
        check("R7 enabled but idle peripheral leaves port data", pad_out & 16'h000C, 16'h0000);
        check("R7 full pad_oe", pad_oe, exp_oe());
        bus_write(2'd2, 16'h0001, 2'b11);
        check("R5 latch write does not reach owned pad", pad_out & 16'h0003, 16'h0002);
        check("R5 pad_out overall", pad_out, exp_out());
        @(negedge clk);
        pad_in = 16'h0003;
        @(negedge clk);
        @(negedge clk);
        bus_read(2'd2, r); check("R6 owned pins readable via port", r, 16'h0003);
        check("R9 per_din while peripheral owns", per_din, 16'h0003);
        @(negedge clk);
        per_en = '0; per_oe = '0;
        #1;
        check("R7 ownership returns to port", pad_out, exp_out());
    endtask

    task automatic t_absent();
        logic [15:0] r;
        bus_write(2'd0, 16'h0000, 2'b11);
        bus_write(2'd1, 16'hFFFF, 2'b11);
        bus_read(2'd1, r); check("R8 latch absent bits zero", r, MASK);
        bus_read(2'd0, r); check("R8 dir absent bits zero", r, 16'h0000);
        check("R8 absent pads not driven", pad_oe & ~MASK, 16'h0000);
        @(negedge clk);
        pad_in = 16'hFFFF; per_en = 16'hFFFF; per_oe = 16'hFFFF; per_dout = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        bus_read(2'd2, r); check("R8 port absent bits zero", r, MASK);
        check("R8 absent per_din zero", per_din, MASK);
        check("R8 absent pad_oe with peripheral", pad_oe, MASK);
        per_en = '0; per_oe = '0; per_dout = '0;
    endtask

    task automatic t_byte_enable();
        logic [15:0] r;
        bus_write(2'd1, 16'h0000, 2'b11);
        bus_write(2'd1, 16'hABCD, 2'b01);
        bus_read(2'd1, r); check("R10 low byte only", r, 16'h00CD);
        bus_write(2'd0, 16'h1200, 2'b10);
        bus_read(2'd0, r); check("R10 high byte only", r, m_dir);
        check("R10 model dir", r, 16'h1200);
    endtask

    task automatic t_addr3();
        logic [15:0] r;
        bus_write(2'd3, 16'hFFFF, 2'b11);
        bus_read(2'd3, r); check("R11 address 3 reads zero", r, 16'h0000);
        bus_read(2'd0, r); check("R11 dir unchanged", r, m_dir);
        bus_read(2'd1, r); check("R11 latch unchanged", r, m_lat);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_dir = MASK;
        m_lat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_latch_vs_port();
        t_periph();
        t_absent();
        t_byte_enable();
        t_addr3();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule